// File: doc/BRIEF.md
# Hybrid Half/Full-Bridge Speed Modulator

This block picks, once per drive period, whether the motor's bridge pair runs as a full bridge or as a half bridge. In a full bridge both legs switch in antiphase. In a half bridge one leg switches and the other stays low. Over many periods, the share of full-bridge periods follows a speed setting from 0 to 128. The average voltage across the motor is therefore the supply plus setting/128 of the supply: a setting of 32 gives 1.25 times the supply, and a setting of 96 gives 1.75 times.

The pulse sequencer raises a one-cycle strobe at each period boundary while pulse generation runs. On that strobe, a first-order accumulator adds the setting. When the sum reaches 128, the block selects full bridge for the coming period and removes 128 from the sum. This spreads the full-bridge periods evenly through the move.

When half-bridge mode is enabled and a clean digital supply-above-threshold flag is high, every period is forced to half bridge. This lockout overrides the hybrid setting. Hysteresis on that flag is handled upstream.

Top module: `hybrid_bridge_mod`

## Requirements
- R1: After reset the speed setting is 128, the accumulator is empty and `full_sel` is 1. `full_sel` is 1 for full bridge and 0 for half bridge.
- R2: A write through `spd_we` with a value above 128 stores 128. A value of 0 to 128 is stored as written.
- R3: With `hyb_en` low and no lockout, every period strobe selects full bridge.
- R4: With `hyb_en` high and no lockout, each strobe adds the setting to the accumulator. If the sum is 128 or more, the period is full bridge and 128 is removed; otherwise the period is half bridge and the sum is kept. A setting of 0 gives all half-bridge periods and 128 gives all full-bridge periods.
- R5: While `hb_en` and `vdd_high` are both high, every strobe selects half bridge, whatever the hybrid settings are. The accumulator keeps its value across such periods.
- R6: `full_sel` changes only on the cycle after a strobe taken while `run` is high, or when `run` drops. Changes to the setting or the mode inputs between strobes have no effect until the next strobe.
- R7: When `run` is low, the accumulator is cleared and `full_sel` returns to 1 on the next cycle, so every move starts from the same pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spd_we | input | 1 | Write strobe for the speed setting |
| spd_wdata | input | SPD_W | Speed value to write (saturated to 128) |
| hyb_en | input | 1 | Enables hybrid full/half mixing |
| hb_en | input | 1 | Enables the supply-dependent half-bridge lockout |
| vdd_high | input | 1 | Supply-above-threshold flag, already debounced |
| run | input | 1 | Pulse generation active |
| period_stb | input | 1 | One-cycle strobe at each drive period boundary |
| full_sel | output | 1 | Mode of the current period: 1 full bridge, 0 half bridge |

## Verification
The hardest state to reach is an accumulator that keeps its partial sum through a lockout and then resumes. No port shows that sum directly. The bench therefore drives a setting of 64, takes one half-bridge period, and raises the lockout for one strobe. It then drops the lockout: the next period must be full bridge, which only happens if the held remainder of 64 survived. A second run is stopped after two periods and restarted, and the restarted pattern must again begin with three half-bridge periods.

// File: rtl/hybrid_bridge_mod.sv
module hybrid_bridge_mod #(
  parameter int SPD_W      = 8,
  parameter int FULL_SCALE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_we,
  input  logic [SPD_W-1:0] spd_wdata,
  input  logic             hyb_en,
  input  logic             hb_en,
  input  logic             vdd_high,
  input  logic             run,
  input  logic             period_stb,
  output logic             full_sel
);

  localparam logic [SPD_W-1:0] FS   = SPD_W'(FULL_SCALE);
  localparam logic [SPD_W:0]   FS_X = {1'b0, FS};

  logic [SPD_W-1:0] spd_q;
  logic [SPD_W-1:0] acc_q;
  logic [SPD_W:0]   sum;
  logic [SPD_W:0]   rem;
  logic             lockout;
  logic             carry;

  assign lockout = hb_en & vdd_high;
  assign sum     = {1'b0, acc_q} + {1'b0, spd_q};
  assign carry   = sum >= FS_X;
  assign rem     = sum - FS_X;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      spd_q <= FS;
    else if (spd_we) spd_q <= (spd_wdata > FS) ? FS : spd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      full_sel <= 1'b1;
    end else if (!run) begin
      acc_q    <= '0;
      full_sel <= 1'b1;
    end else if (period_stb) begin
      if (lockout) begin
        full_sel <= 1'b0;
      end else if (!hyb_en) begin
        full_sel <= 1'b1;
      end else begin
        full_sel <= carry;
        acc_q    <= carry ? rem[SPD_W-1:0] : sum[SPD_W-1:0];
      end
    end
  end

  AST_SPD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    spd_we |=> spd_q <= FS); // R2

  AST_NO_HYB_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period_stb && !hyb_en && !(hb_en && vdd_high)) |=> full_sel); // R3

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < FS); // R4

  AST_LOCKOUT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period_stb && hb_en && vdd_high) |=> !full_sel); // R5

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period_stb && hb_en && vdd_high) |=> $stable(acc_q)); // R5

  AST_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_stb) |=> $stable(full_sel)); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (full_sel && acc_q == '0)); // R7

endmodule

// File: tb/hybrid_bridge_mod_tb.sv
module hybrid_bridge_mod_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spd_we = 1'b0;
  logic [7:0] spd_wdata = '0;
  logic       hyb_en = 1'b0;
  logic       hb_en = 1'b0;
  logic       vdd_high = 1'b0;
  logic       run = 1'b0;
  logic       period_stb = 1'b0;
  logic       full_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hybrid_bridge_mod u_dut (
    .clk(clk), .rst_n(rst_n), .spd_we(spd_we), .spd_wdata(spd_wdata),
    .hyb_en(hyb_en), .hb_en(hb_en), .vdd_high(vdd_high), .run(run),
    .period_stb(period_stb), .full_sel(full_sel)
  );

  // {speed, hyb_en, hb_en, vdd_high, expected modes of periods 7..0}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {8'd32,  3'b100, 8'b1000_1000},  // R4
    {8'd96,  3'b100, 8'b1110_1110},  // R4
    {8'd64,  3'b100, 8'b1010_1010},  // R4
    {8'd0,   3'b100, 8'b0000_0000},  // R4
    {8'd128, 3'b100, 8'b1111_1111},  // R4
    {8'd1,   3'b100, 8'b0000_0000},  // R4
    {8'd127, 3'b100, 8'b1111_1110},  // R4
    {8'd200, 3'b100, 8'b1111_1111},  // R2
    {8'd0,   3'b000, 8'b1111_1111},  // R3
    {8'd128, 3'b111, 8'b0000_0000},  // R5
    {8'd32,  3'b110, 8'b1000_1000},  // R5
    {8'd32,  3'b101, 8'b1000_1000}   // R5
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: full_sel=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic write_spd(input logic [7:0] v);
    @(negedge clk); spd_we = 1'b1; spd_wdata = v;
    @(negedge clk); spd_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); period_stb = 1'b1;
    @(negedge clk); period_stb = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk); run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", full_sel, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release", full_sel, 1'b1);

    // R1: default setting 128 gives all full-bridge periods in hybrid mode
    hyb_en = 1'b1; run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      strobe();
      check("R1 default speed 128", full_sel, 1'b1);
    end
    stop_run();

    for (int v = 0; v < NV; v++) begin
      write_spd(VEC[v][18:11]);
      hyb_en = VEC[v][10]; hb_en = VEC[v][9]; vdd_high = VEC[v][8];
      run = 1'b1;
      for (int p = 0; p < 8; p++) begin
        strobe();
        check($sformatf("R4/R3/R5/R2 vector %0d period %0d", v, p), full_sel, VEC[v][p]);
      end
      stop_run();
      check("R7 idle returns full", full_sel, 1'b1);
    end
    hb_en = 1'b0; vdd_high = 1'b0;

    // R7: restart after a partial move repeats the same pattern
    write_spd(8'd32); hyb_en = 1'b1; run = 1'b1;
    strobe(); strobe();
    stop_run();
    run = 1'b1;
    for (int p = 0; p < 4; p++) begin
      strobe();
      check("R7 restart pattern", full_sel, p == 3);
    end

    // R6: inputs changed between strobes have no effect on the current period
    @(negedge clk); spd_we = 1'b1; spd_wdata = 8'd128; hyb_en = 1'b0;
    @(negedge clk); spd_we = 1'b0; hb_en = 1'b1; vdd_high = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 hold mid-period", full_sel, 1'b1);
    strobe();
    check("R6 lockout taken at strobe", full_sel, 1'b0);
    hb_en = 1'b0; vdd_high = 1'b0;
    stop_run();

    // R5: accumulator held through a lockout period
    write_spd(8'd64); hyb_en = 1'b1; run = 1'b1;
    strobe();
    check("R5 first period half", full_sel, 1'b0);
    hb_en = 1'b1; vdd_high = 1'b1;
    strobe();
    check("R5 lockout period half", full_sel, 1'b0);
    hb_en = 1'b0; vdd_high = 1'b0;
    strobe();
    check("R5 held remainder gives full", full_sel, 1'b1);
    stop_run();

    // R2: boundary value 128 and 129
    write_spd(8'd129); run = 1'b1;
    strobe();
    check("R2 129 saturates to full", full_sel, 1'b1);
    strobe();
    check("R2 129 saturates second period", full_sel, 1'b1);
    stop_run();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule